// File: doc/BRIEF.md
# Microcode ALU with Condition Flags

This block is the arithmetic and logic unit of a microcoded datapath. It takes two 32-bit operands and a 4-bit function code and produces a 32-bit result in the same cycle. It also produces negative, zero, overflow and carry flags. The sixteen functions are the ones microcode needs to interpret an instruction stream. They are bitwise logic, addition, a variable logical right shift, fixed left shifts by 2 and 10, zero-extension and sign-extension of a 13-bit immediate, increment by one, increment by four for stepping a word-aligned program counter, and a fixed 5-bit arithmetic right shift that helps decode branch fields.

Four of the codes are flag-setting variants of the logic and add operations. For those codes the block raises a set-condition-codes strobe. A small status register inside the block captures the four flags on the rising clock edge only while the strobe is high. Microcode can therefore route data through the ALU without disturbing the stored flags.

Top module: `cc_alu`

## Requirements
- R1: Function codes: 0000 AND-set, 0001 OR-set, 0010 NOR-set, 0011 ADD-set, 0100 SRL, 0101 AND, 0110 OR, 0111 NOR, 1000 ADD, 1001 SHL2, 1010 SHL10, 1011 ZEXT13, 1100 SEXT13, 1101 INC1, 1110 INC4, 1111 ASR5. The logic codes give the bitwise AND, OR or NOR of A and B. A flag-setting code and its plain twin give the same result.
- R2: ADD and ADD-set give (A + B) mod 2^32.
- R3: SRL shifts A right by B[4:0] and fills with zeros. B[31:5] has no effect on the result.
- R4: SHL2 and SHL10 shift A left by 2 and by 10 and fill with zeros.
- R5: ZEXT13 gives {19'b0, A[12:0]}. SEXT13 copies A[12] into bits 31:13 of the result.
- R6: INC1 gives (A + 1) mod 2^32 and INC4 gives (A + 4) mod 2^32. B has no effect on either.
- R7: ASR5 shifts A right by 5 and copies A[31] into result bits 31:27.
- R8: `flag_n` equals result bit 31. `flag_z` is 1 exactly when all 32 result bits are 0.
- R9: For ADD, ADD-set, INC1 and INC4, `flag_c` is the carry out of bit 31 and `flag_v` is the carry into bit 31 XOR the carry out of bit 31. For every other code both are 0.
- R10: `set_cc` is 1 exactly when func[3:2] is 00.
- R11: `cc_q` = {N,Z,V,C} is 0 after reset. It loads the current flags on a rising clock edge where `set_cc` is 1 and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| func | input | 4 | Function code |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Negative flag of the current result |
| flag_z | output | 1 | Zero flag of the current result |
| flag_v | output | 1 | Overflow flag of the current result |
| flag_c | output | 1 | Carry flag of the current result |
| set_cc | output | 1 | Flag-update strobe |
| cc_q | output | 4 | Stored flags {N,Z,V,C} |

## Verification
Two functions can act in the same cycle: the combinational flag computation for the current code and the capture of flags into the stored register. The bench provokes the overlap by issuing an overflowing ADD-set followed by a plain ADD that produces different flags, and then a logic operation with a zero result. After each clock edge it compares the stored flags with the values from the most recent flag-setting code only. The live flag outputs must meanwhile follow the current code.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;
    localparam int DW = 32;
    localparam int SHW = $clog2(DW);

    typedef enum logic [3:0] {
        OP_ANDS  = 4'b0000,
        OP_ORS   = 4'b0001,
        OP_NORS  = 4'b0010,
        OP_ADDS  = 4'b0011,
        OP_SRL   = 4'b0100,
        OP_AND   = 4'b0101,
        OP_OR    = 4'b0110,
        OP_NOR   = 4'b0111,
        OP_ADD   = 4'b1000,
        OP_SHL2  = 4'b1001,
        OP_SHL10 = 4'b1010,
        OP_ZX13  = 4'b1011,
        OP_SX13  = 4'b1100,
        OP_INC1  = 4'b1101,
        OP_INC4  = 4'b1110,
        OP_ASR5  = 4'b1111
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;
endpackage

// File: rtl/cc_alu_adder.sv
module cc_alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             c_msb_in
);
    logic [WIDTH-1:0] low;
    logic [1:0]       top;

    always_comb begin
        low      = {1'b0, x[WIDTH-2:0]} + {1'b0, y[WIDTH-2:0]};
        c_msb_in = low[WIDTH-1];
        top      = {1'b0, x[WIDTH-1]} + {1'b0, y[WIDTH-1]} + {1'b0, c_msb_in};
        c_out    = top[1];
        sum      = {top[0], low[WIDTH-2:0]};
    end
endmodule

// File: rtl/cc_alu_shifter.sv
module cc_alu_shifter #(
    parameter int WIDTH = 32,
    localparam int LEVELS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  din,
    input  logic [LEVELS-1:0] amount,
    input  logic              go_right,
    input  logic              fill_sign,
    output logic [WIDTH-1:0]  dout
);
    logic [WIDTH-1:0] stage [LEVELS+1];
    logic             fill;

    assign fill     = fill_sign & go_right & din[WIDTH-1];
    assign stage[0] = din;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int STEP = 1 << lv;
        logic [WIDTH-1:0] moved;
        always_comb begin
            if (go_right)
                moved = {{STEP{fill}}, stage[lv][WIDTH-1:STEP]};
            else
                moved = {stage[lv][WIDTH-1-STEP:0], {STEP{1'b0}}};
        end
        assign stage[lv+1] = amount[lv] ? moved : stage[lv];
    end

    assign dout = stage[LEVELS];
endmodule

// File: rtl/cc_alu_flagreg.sv
module cc_alu_flagreg
    import cc_alu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  cc_flags_t d,
    output cc_flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R11: no strobe, no change
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
    // R11: strobe loads the flags present at the edge
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   opa,
    input  logic [31:0]   opb,
    input  logic [3:0]    func,
    output logic [31:0]   result,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c,
    output logic          set_cc,
    output logic [3:0]    cc_q
);
    localparam int IMMW = 13;

    alu_op_e          op;
    logic [DW-1:0]    add_y, add_sum;
    logic             add_co, add_cmsb, use_adder;
    logic [SHW-1:0]   sh_amt;
    logic             sh_right, sh_arith;
    logic [DW-1:0]    sh_out;
    cc_flags_t        flags, flags_q;

    assign op = alu_op_e'(func);

    always_comb begin
        unique case (op)
            OP_INC1: add_y = DW'(1);
            OP_INC4: add_y = DW'(4);
            default: add_y = opb;
        endcase
        use_adder = (op == OP_ADD) || (op == OP_ADDS) ||
                    (op == OP_INC1) || (op == OP_INC4);
    end

    cc_alu_adder #(.WIDTH(DW)) u_add (
        .x(opa), .y(add_y), .sum(add_sum),
        .c_out(add_co), .c_msb_in(add_cmsb)
    );

    always_comb begin
        sh_right = 1'b1;
        sh_arith = 1'b0;
        sh_amt   = opb[SHW-1:0];
        unique case (op)
            OP_SHL2:  begin sh_right = 1'b0; sh_amt = SHW'(2);  end
            OP_SHL10: begin sh_right = 1'b0; sh_amt = SHW'(10); end
            OP_ASR5:  begin sh_arith = 1'b1; sh_amt = SHW'(5);  end
            default:  ;
        endcase
    end

    cc_alu_shifter #(.WIDTH(DW)) u_shift (
        .din(opa), .amount(sh_amt), .go_right(sh_right),
        .fill_sign(sh_arith), .dout(sh_out)
    );

    always_comb begin
        unique case (op)
            OP_ANDS, OP_AND: result = opa & opb;
            OP_ORS,  OP_OR:  result = opa | opb;
            OP_NORS, OP_NOR: result = ~(opa | opb);
            OP_ADDS, OP_ADD, OP_INC1, OP_INC4: result = add_sum;
            OP_SRL, OP_SHL2, OP_SHL10, OP_ASR5: result = sh_out;
            OP_ZX13: result = {{(DW-IMMW){1'b0}}, opa[IMMW-1:0]};
            OP_SX13: result = {{(DW-IMMW){opa[IMMW-1]}}, opa[IMMW-1:0]};
        endcase
    end

    always_comb begin
        flags.n = result[DW-1];
        flags.z = ~|result;
        flags.c = use_adder & add_co;
        flags.v = use_adder & (add_co ^ add_cmsb);
    end

    assign set_cc = (func[3:2] == 2'b00);
    assign {flag_n, flag_z, flag_v, flag_c} = flags;

    cc_alu_flagreg u_cc (
        .clk(clk), .rst_n(rst_n), .load(set_cc), .d(flags), .q(flags_q)
    );
    assign cc_q = flags_q;

    // R9: logic codes never report carry or overflow
    a_r9_logic_no_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (func inside {4'b0000, 4'b0001, 4'b0010, 4'b0101, 4'b0110, 4'b0111})
        |-> (!flag_c && !flag_v));
    // R3: a nonzero logical right shift leaves bit 31 clear
    a_r3_srl_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b0100 && opb[4:0] != 5'd0) |-> !result[31]);
    // R7: arithmetic shift by five replicates the sign
    a_r7_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'b1111) |-> (result[31:27] == {5{opa[31]}}));
    // R8: zero flag matches the result bus
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        flag_z == (result == 32'd0));
endmodule

// File: tb/cc_alu_test.sv
module cc_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [3:0]  func = 4'b0101;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, set_cc;
    logic [3:0]  cc_q;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    cc_alu uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_res(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        case (f)
            4'd0, 4'd5: return a & b;
            4'd1, 4'd6: return a | b;
            4'd2, 4'd7: return ~(a | b);
            4'd3, 4'd8: return a + b;
            4'd4:       return a >> b[4:0];
            4'd9:       return a << 2;
            4'd10:      return a << 10;
            4'd11:      return {19'd0, a[12:0]};
            4'd12:      return {{19{a[12]}}, a[12:0]};
            4'd13:      return a + 1;
            4'd14:      return a + 4;
            default:    return $signed(a) >>> 5;
        endcase
    endfunction

    function automatic logic [3:0] ref_flags(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r, y;
        logic [32:0] s;
        logic c, v;
        r = ref_res(f, a, b);
        c = 0; v = 0;
        if (f == 4'd3 || f == 4'd8 || f == 4'd13 || f == 4'd14) begin
            y = (f == 4'd13) ? 32'd1 : (f == 4'd14) ? 32'd4 : b;
            s = {1'b0, a} + {1'b0, y};
            c = s[32];
            v = (a[31] == y[31]) && (s[31] != a[31]);
        end
        return {r[31], r == 0, v, c};
    endfunction

    // apply at negedge, sample combinational outputs 1 ns later
    task automatic apply(input string req, input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        func = f; opa = a; opb = b;
        #1;
        chk(req, result, ref_res(f, a, b));
        chk({req, " flags"}, {28'd0, flag_n, flag_z, flag_v, flag_c}, {28'd0, ref_flags(f, a, b)});
        chk("R10", {31'd0, set_cc}, {31'd0, f[3:2] == 2'b00});
    endtask

    task automatic t_reset;
        chk("R11 reset", {28'd0, cc_q}, 32'd0);
    endtask

    task automatic t_logic;
        apply("R1", 4'd0, 32'hF0F0_1234, 32'h0FF0_FFFF);
        apply("R1", 4'd5, 32'hF0F0_1234, 32'h0FF0_FFFF);
        apply("R1", 4'd1, 32'h8000_0001, 32'h0000_0100);
        apply("R1", 4'd6, 32'h0, 32'h0);
        apply("R1", 4'd2, 32'h0, 32'h0);
        apply("R1", 4'd7, 32'hFFFF_FFFF, 32'h0);
    endtask

    task automatic t_add;
        apply("R2 R9", 4'd8, 32'h7FFF_FFFF, 32'h1);
        apply("R2 R9", 4'd3, 32'hFFFF_FFFF, 32'h1);
        apply("R2 R9", 4'd8, 32'h8000_0000, 32'h8000_0000);
        apply("R2", 4'd3, 32'h1234_5678, 32'h1111_1111);
    endtask

    task automatic t_shifts;
        apply("R3", 4'd4, 32'h8000_0000, 32'd31);
        apply("R3", 4'd4, 32'hDEAD_BEEF, 32'hFFFF_FFE0);
        apply("R3", 4'd4, 32'hDEAD_BEEF, 32'h0000_0047);
        apply("R4", 4'd9, 32'hC000_0003, 32'h5);
        apply("R4", 4'd10, 32'hFFC0_0001, 32'h0);
        apply("R7", 4'd15, 32'h8000_0020, 32'h0);
        apply("R7", 4'd15, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_ext;
        apply("R5", 4'd11, 32'hFFFF_F123, 32'h0);
        apply("R5", 4'd12, 32'h0000_1000, 32'h0);
        apply("R5", 4'd12, 32'hFFFF_0FFF, 32'h0);
    endtask

    task automatic t_inc;
        apply("R6 R9", 4'd13, 32'hFFFF_FFFF, 32'h1234);
        apply("R6", 4'd14, 32'h0000_0FFC, 32'hFFFF_FFFF);
        apply("R6 R9", 4'd14, 32'h7FFF_FFFC, 32'h0);
    endtask

    task automatic t_ccreg;
        logic [3:0] keep;
        apply("R8", 4'd3, 32'h7FFF_FFFF, 32'h1);      // N=1 V=1
        keep = ref_flags(4'd3, 32'h7FFF_FFFF, 32'h1);
        apply("R8", 4'd8, 32'hFFFF_FFFF, 32'h1);      // Z=1 C=1, no capture
        chk("R11 load", {28'd0, cc_q}, {28'd0, keep});
        apply("R11", 4'd5, 32'h0, 32'h0);             // plain AND, zero
        chk("R11 hold", {28'd0, cc_q}, {28'd0, keep});
        apply("R11", 4'd0, 32'h0F, 32'hF0);           // ANDCC zero
        apply("R11", 4'd6, 32'h1, 32'h0);
        chk("R11 load2", {28'd0, cc_q}, 32'h4);
    endtask

    initial begin
        #25;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_logic();
        t_add();
        t_shifts();
        t_ext();
        t_inc();
        t_ccreg();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule